// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the integer datapath slice of a 16-bit processor core. It adds, subtracts, compares, increments, decrements, negates and applies bitwise AND, OR, XOR and TEST to two operands. Each operation works on either a byte (the low 8 bits) or a full 16-bit word. The result and its write enable are combinational from the inputs. A 16-bit flags register holds the status flags and the control flags, and it loads on the clock edge of each accepted operation.

The status set is carry, parity, auxiliary carry, zero, sign and overflow. Which of these an operation changes depends on the operation: increment and decrement keep the carry, and the bitwise operations clear carry, overflow and auxiliary carry. The control flags and the privilege field never change through arithmetic. A separate write port loads the whole register. Compare and test only set flags, so they never raise the result write enable.

Top module: `alu_flags_unit`

## Requirements
- R1: After reset `flags_q` is 16'h0002. The flag bit positions are carry 0, parity 2, aux 4, zero 6, sign 7, trace 8, int-enable 9, direction 10, overflow 11, privilege 13:12 and nested 14. Bit 1 always reads 1, and bits 3, 5 and 15 always read 0.
- R2: `op_code` 0..11 selects ADD, ADC, SUB, SBB, CMP, INC, DEC, NEG, AND, OR, XOR and TEST. `result` is combinational. When `is_word`=0 only bits 7:0 are used and `result[15:8]` is 0.
- R3: The carry flag (bit 0) holds the carry out of the MSB for additions, and the borrow for SUB, SBB, CMP and DEC. ADC and SBB take `carry_in` as the extra carry or borrow.
- R4: The aux flag (bit 4) holds the carry, or for subtraction the borrow, out of bit 3.
- R5: The overflow flag (bit 11) is set when the signed result does not fit the chosen width.
- R6: The zero flag (bit 6) is set when the result is 0, and the sign flag (bit 7) copies the result MSB for the chosen width. The parity flag (bit 2) is set when `result[7:0]` has an even number of ones, for both widths.
- R7: INC and DEC leave the carry flag unchanged. NEG computes 0 minus the operand and sets the carry flag exactly when the operand is nonzero.
- R8: AND, OR, XOR and TEST clear the carry, overflow and aux flags.
- R9: `result_we` is 1 exactly when `op_valid`=1 and `op_code` is 0..3 or 5..10. CMP and TEST never raise it.
- R10: Operations never change bits 8, 9, 10, 12, 13 and 14. With `flags_wr`=1 the register loads (`flags_wdata` & 16'h7FD5) | 16'h0002 on the next edge, and this takes priority over an operation in the same cycle.
- R11: The flags update on the clock edge of an operation with `op_valid`=1. With `op_valid`=0, or with `op_code` 12..15, the flags hold and `result_we` is 0. An undefined code also gives `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation select |
| is_word | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Incoming carry or borrow for ADC/SBB |
| flags_wr | input | 1 | Load the flags register |
| flags_wdata | input | 16 | Value for a flags load |
| result | output | 16 | Operation result |
| result_we | output | 1 | Result should be written back |
| flags_q | output | 16 | Flags register |

## Verification
The assertions check, on every cycle, the fixed bits of the flags register and that the control bits hold across operations. They also check that increment and decrement keep the carry, that bitwise operations clear carry and overflow, that the zero flag agrees with the previous result, and that compare and test never raise the write enable. The exact values of carry, borrow, aux carry, overflow and parity for given operands can only be shown by the bench's scenarios. The same holds for the byte-mode upper-half clearing and for the priority of a flags load over a same-cycle operation. The bench compares these against its own integer model.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned HW = DW / 2;
  localparam int unsigned OPW = 4;

  localparam int unsigned FB_CF = 0;
  localparam int unsigned FB_PF = 2;
  localparam int unsigned FB_AF = 4;
  localparam int unsigned FB_ZF = 6;
  localparam int unsigned FB_SF = 7;
  localparam int unsigned FB_OF = 11;

  localparam logic [DW-1:0] FL_ONE_MASK  = 16'h0002;
  localparam logic [DW-1:0] FL_WR_MASK   = 16'h7FD5;
  localparam logic [DW-1:0] FL_CTRL_MASK = 16'h7700;
  localparam logic [DW-1:0] FL_STAT_MASK = 16'h08D5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,  OP_INC = 4'd5,  OP_DEC = 4'd6,  OP_NEG  = 4'd7,
    OP_AND  = 4'd8,  OP_OR  = 4'd9,  OP_XOR = 4'd10, OP_TEST = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          cf;
    logic          af;
    logic          of;
  } arith_t;

  function automatic logic parity_even(input logic [HW-1:0] v);
    return ~^v;
  endfunction

  function automatic logic width_msb(input logic [DW-1:0] v, input logic word);
    return word ? v[DW-1] : v[HW-1];
  endfunction

  // Shared adder: subtraction is a + ~b + ~borrow; carry outputs are
  // inverted for subtraction so they read as borrows.
  function automatic arith_t add_core(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                      input logic sub, input logic cin, input logic word);
    arith_t r;
    logic [DW-1:0] bb;
    logic ci;
    logic [DW:0] s;
    logic c_lo, am, bm, sm;
    bb = sub ? ~b : b;
    ci = sub ? ~cin : cin;
    s  = {1'b0, a} + {1'b0, bb} + {{DW{1'b0}}, ci};
    c_lo = a[HW] ^ bb[HW] ^ s[HW];
    r.cf = (word ? s[DW] : c_lo) ^ sub;
    r.af = (a[4] ^ bb[4] ^ s[4]) ^ sub;
    am = width_msb(a, word);
    bm = width_msb(bb, word);
    sm = width_msb(s[DW-1:0], word);
    r.of = (am == bm) && (sm != am);
    r.res = word ? s[DW-1:0] : {{(DW-HW){1'b0}}, s[HW-1:0]};
    return r;
  endfunction
endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_flags_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic           is_word,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic           carry_in,
  output arith_t         arith_out
);
  logic [DW-1:0] x, y;
  logic          sub, cin;

  always_comb begin
    x = op_a;
    y = op_b;
    sub = 1'b0;
    cin = 1'b0;
    unique case (op_code)
      OP_ADC:                 cin = carry_in;
      OP_SUB, OP_CMP:         sub = 1'b1;
      OP_SBB: begin           sub = 1'b1; cin = carry_in; end
      OP_INC:                 y = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin           y = {{(DW-1){1'b0}}, 1'b1}; sub = 1'b1; end
      OP_NEG: begin           x = '0; y = op_a; sub = 1'b1; end
      default: ;
    endcase
    arith_out = add_core(x, y, sub, cin, is_word);
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_flags_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic           is_word,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  output logic [DW-1:0]  logic_res
);
  logic [DW-1:0] raw;
  always_comb begin
    unique case (op_code)
      OP_OR:   raw = op_a | op_b;
      OP_XOR:  raw = op_a ^ op_b;
      default: raw = op_a & op_b;
    endcase
    logic_res = is_word ? raw : {{(DW-HW){1'b0}}, raw[HW-1:0]};
  end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import alu_flags_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  input  logic           is_word,
  input  arith_t         arith_in,
  input  logic [DW-1:0]  logic_res,
  input  logic [DW-1:0]  flags_cur,
  output logic [DW-1:0]  result,
  output logic           op_known,
  output logic           op_writes,
  output logic [DW-1:0]  flags_nxt
);
  logic is_logic, keep_cf;
  logic [DW-1:0] stat, upd_mask;

  always_comb begin
    is_logic  = op_code inside {OP_AND, OP_OR, OP_XOR, OP_TEST};
    op_known  = op_code <= OP_TEST;
    op_writes = op_known && (op_code != OP_CMP) && (op_code != OP_TEST);
    keep_cf   = op_code inside {OP_INC, OP_DEC};
    if (!op_known)     result = '0;
    else if (is_logic) result = logic_res;
    else               result = arith_in.res;

    stat = '0;
    stat[FB_CF] = is_logic ? 1'b0 : arith_in.cf;
    stat[FB_AF] = is_logic ? 1'b0 : arith_in.af;
    stat[FB_OF] = is_logic ? 1'b0 : arith_in.of;
    stat[FB_PF] = parity_even(result[HW-1:0]);
    stat[FB_ZF] = (result == '0);
    stat[FB_SF] = width_msb(result, is_word);

    upd_mask = FL_STAT_MASK;
    if (keep_cf) upd_mask[FB_CF] = 1'b0;
    flags_nxt = op_known ? ((flags_cur & ~upd_mask) | (stat & upd_mask)) : flags_cur;
  end

  // R1: a known operation never disturbs the fixed bits
  always_comb begin
    assert_fixed_bits_R1: assert (!op_known || flags_cur[1] != 1'b1 || flags_nxt[1] == 1'b1);
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic           is_word,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic           carry_in,
  input  logic           flags_wr,
  input  logic [DW-1:0]  flags_wdata,
  output logic [DW-1:0]  result,
  output logic           result_we,
  output logic [DW-1:0]  flags_q
);
  arith_t        arith_w;
  logic [DW-1:0] logic_w, flags_nxt;
  logic          op_known, op_writes;
  logic          op_fire;

  alu_arith_unit u_arith (
    .op_code(op_code), .is_word(is_word), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .arith_out(arith_w)
  );

  alu_logic_unit u_logic (
    .op_code(op_code), .is_word(is_word), .op_a(op_a), .op_b(op_b),
    .logic_res(logic_w)
  );

  alu_flag_merge u_merge (
    .op_code(op_code), .is_word(is_word), .arith_in(arith_w), .logic_res(logic_w),
    .flags_cur(flags_q), .result(result), .op_known(op_known),
    .op_writes(op_writes), .flags_nxt(flags_nxt)
  );

  assign result_we = op_valid && op_writes;
  assign op_fire   = op_valid && op_known && !flags_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)        flags_q <= FL_ONE_MASK;
    else if (flags_wr) flags_q <= (flags_wdata & FL_WR_MASK) | FL_ONE_MASK;
    else if (op_fire)  flags_q <= flags_nxt;
  end

  assert_fixed_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[1] && !flags_q[3] && !flags_q[5] && !flags_q[15]);

  assert_incdec_keep_cf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && (op_code == OP_INC || op_code == OP_DEC)) |=> $stable(flags_q[FB_CF]));

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fire && op_code inside {OP_AND, OP_OR, OP_XOR, OP_TEST})
      |=> (!flags_q[FB_CF] && !flags_q[FB_OF] && !flags_q[FB_AF]));

  assert_cmp_test_no_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_CMP || op_code == OP_TEST) |-> !result_we);

  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_wr |=> ((flags_q & FL_CTRL_MASK) == ($past(flags_q) & FL_CTRL_MASK)));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> (flags_q[FB_ZF] == ($past(result) == '0)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !flags_wr) |=> $stable(flags_q));
endmodule

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0, is_word = 1'b0, carry_in = 1'b0, flags_wr = 1'b0;
  logic [3:0]  op_code = 4'd0;
  logic [15:0] op_a = '0, op_b = '0, flags_wdata = '0;
  logic [15:0] result, flags_q;
  logic        result_we;

  int n_checks = 0, n_fails = 0;
  logic [15:0] exp_flags = 16'h0002;
  logic [15:0] q_res[$], q_flg[$];
  logic        q_we[$];
  string       q_tag[$];

  always #4 clk = ~clk;  // 125 MHz

  alu_flags_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .is_word(is_word), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .flags_wr(flags_wr), .flags_wdata(flags_wdata), .result(result),
    .result_we(result_we), .flags_q(flags_q)
  );

  task automatic check16(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Independent integer model of the requirements
  task automatic model(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic word, input logic cin, input logic valid,
                       output logic [15:0] eres, output logic ewe);
    int mask, half, ua, ub, c, full, nib, sa, sb, sr, res, ones;
    bit sub, lg, known, cf, af, of;
    mask = word ? 65535 : 255;
    half = word ? 32768 : 128;
    ua = int'(a) & mask; ub = int'(b) & mask; c = 0; sub = 0; lg = 0; known = 1;
    res = 0; cf = 0; af = 0; of = 0;
    case (op)
      4'd0: ;
      4'd1: c = int'(cin);
      4'd2, 4'd4: sub = 1;
      4'd3: begin sub = 1; c = int'(cin); end
      4'd5: ub = 1;
      4'd6: begin ub = 1; sub = 1; end
      4'd7: begin ub = ua; ua = 0; sub = 1; end
      4'd8, 4'd11: begin lg = 1; res = ua & ub; end
      4'd9:  begin lg = 1; res = ua | ub; end
      4'd10: begin lg = 1; res = ua ^ ub; end
      default: known = 0;
    endcase
    if (known && !lg) begin
      full = sub ? ua - ub - c : ua + ub + c;
      nib  = sub ? (ua & 15) - (ub & 15) - c : (ua & 15) + (ub & 15) + c;
      res  = full & mask;
      cf   = sub ? (full < 0) : (full > mask);
      af   = sub ? (nib < 0) : (nib > 15);
      sa = (ua >= half) ? ua - 2 * half : ua;
      sb = (ub >= half) ? ub - 2 * half : ub;
      sr = sub ? sa - sb - c : sa + sb + c;
      of = (sr >= half) || (sr < -half);
    end
    eres = known ? 16'(res) : 16'h0;
    ewe  = valid && known && op != 4'd4 && op != 4'd11;
    if (valid && known) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (res >> i) & 1;
      if (!(op == 4'd5 || op == 4'd6)) exp_flags[0] = cf;
      exp_flags[2]  = (ones % 2) == 0;
      exp_flags[4]  = af;
      exp_flags[6]  = (res == 0);
      exp_flags[7]  = (res >= half);
      exp_flags[11] = of;
    end
  endtask

  task automatic drive(input string tag, input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic word, input logic cin,
                       input logic valid, input logic wr, input logic [15:0] wdata);
    logic [15:0] er, saved;
    logic ew;
    saved = exp_flags;
    model(op, a, b, word, cin, valid, er, ew);
    if (wr) exp_flags = (wdata & 16'h7FD5) | 16'h0002;
    if (!valid && !wr) exp_flags = saved;
    @(negedge clk);
    op_code = op; op_a = a; op_b = b; is_word = word; carry_in = cin;
    op_valid = valid; flags_wr = wr; flags_wdata = wdata;
    q_res.push_back(er); q_we.push_back(ew); q_flg.push_back(exp_flags); q_tag.push_back(tag);
  endtask

  // Monitor: inputs are stable from the negedge, flags have just loaded
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_res.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        check16(t, "result", result, q_res.pop_front());
        check16(t, "result_we", {15'h0, result_we}, {15'h0, q_we.pop_front()});
        check16(t, "flags", flags_q, q_flg.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check16("R1", "reset flags", flags_q, 16'h0002);
    @(negedge clk); rst_n = 1'b1;

    drive("R5_add_word_ovf", 4'd0, 16'h7FFF, 16'h0001, 1, 0, 1, 0, 0);
    drive("R3_R4_R6_add_byte_carry", 4'd0, 16'hABFF, 16'h1201, 0, 0, 1, 0, 0);
    drive("R2_R3_adc_byte_cin", 4'd1, 16'h00F0, 16'h000F, 0, 1, 1, 0, 0);
    drive("R3_sub_word_borrow", 4'd2, 16'h0000, 16'h0001, 1, 0, 1, 0, 0);
    drive("R7_inc_keeps_cf", 4'd5, 16'h000F, 16'h0000, 1, 0, 1, 0, 0);
    drive("R3_sbb_byte", 4'd3, 16'h0080, 16'h0001, 0, 1, 1, 0, 0);
    drive("R7_dec_word_ovf", 4'd6, 16'h8000, 16'h0000, 1, 0, 1, 0, 0);
    drive("R9_cmp_equal", 4'd4, 16'h1234, 16'h1234, 1, 0, 1, 0, 0);
    drive("R7_neg_zero", 4'd7, 16'h0000, 16'h0000, 1, 0, 1, 0, 0);
    drive("R7_neg_nonzero", 4'd7, 16'h0005, 16'h0000, 0, 0, 1, 0, 0);
    drive("R8_and_clears", 4'd8, 16'hF0F0, 16'hFF00, 1, 0, 1, 0, 0);
    drive("R6_or_parity", 4'd9, 16'h0003, 16'h0004, 0, 0, 1, 0, 0);
    drive("R6_xor_zero", 4'd10, 16'h5A5A, 16'h5A5A, 1, 0, 1, 0, 0);
    drive("R3_sub_setcf", 4'd2, 16'h0001, 16'h0002, 1, 0, 1, 0, 0);
    drive("R8_R9_test", 4'd11, 16'h8001, 16'h8000, 1, 0, 1, 0, 0);
    drive("R6_pf_low_byte", 4'd0, 16'h0100, 16'h0000, 1, 0, 1, 0, 0);
    drive("R10_flags_load", 4'd0, 16'h0000, 16'h0000, 1, 0, 0, 1, 16'hFFFF);
    drive("R10_ctrl_kept", 4'd2, 16'h0010, 16'h0001, 1, 0, 1, 0, 0);
    drive("R10_load_priority", 4'd0, 16'hFFFF, 16'hFFFF, 1, 0, 1, 1, 16'h0A01);
    drive("R11_undefined_op", 4'd13, 16'h1234, 16'h4321, 1, 1, 1, 0, 0);
    drive("R11_not_valid", 4'd0, 16'hFFFF, 16'h0001, 1, 0, 0, 0, 0);
    drive("R2_byte_upper_zero", 4'd0, 16'hFF10, 16'hEE20, 0, 0, 1, 0, 0);
    drive("R4_sub_aux_borrow", 4'd2, 16'h0010, 16'h0001, 0, 0, 1, 0, 0);
    drive("R11_idle", 4'd0, 16'h0000, 16'h0000, 0, 0, 0, 0, 0);
    repeat (4) @(posedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule